// File: doc/BRIEF.md
# Peripheral Bus Access Guard

This block sits beside an on-chip peripheral bus and judges every access in the cycle it is presented. It takes the access offset inside the peripheral window, the kind of access (data read, data write or instruction fetch) and whether the requester runs in supervisor or user mode. It then answers with either a pass or an immediate error. Two tiers of programmable rules feed that answer. A small array of per-module codes covers the peripheral windows packed at the bottom of region 0. Two group registers cover the two implemented 64-Mbyte regions. A per-module code always wins over the group register of the region around it.

All codes live in a byte-wide register file reached over a simple read/write configuration port. Each group register has a lock bit that freezes it until the next reset. Regions that have no group register answer every access with an error, and instruction fetches into module windows are always refused.

Top module: `periph_guard`

## Requirements
- R1: After a synchronous reset every configuration byte reads back as 0x00.
- R2: Configuration offsets 0..7 hold the module codes in data bits 3:0, with bits 7:4 reading zero. Offsets 8 and 9 hold the group registers for regions 0 and 1: bit 7 is the lock flag, bits 6:4 read zero and bits 3:0 are the code. Every other offset reads zero and ignores writes. Read data appears on the cycle after the read strobe.
- R3: While a group register's lock bit is 1, writes to that register change nothing, including the lock bit itself.
- R4: The region of an access is acc_addr[29:26]. Any access to regions 2..15 gets acc_err.
- R5: An access is in a module window when the region is 0 and acc_addr[25:16] is below 8. The window index is then acc_addr[18:16], and that module's code alone decides the access. The region-0 group register plays no part.
- R6: An instruction fetch (acc_kind 2'b10 or 2'b11) into a module window always gets acc_err, whatever the module code.
- R7: Read (acc_kind 2'b00) and write (acc_kind 2'b01) rights follow the low three code bits, where "sup" is supervisor and "usr" is user mode:
  - 0: sup read/write
  - 1: sup read only
  - 2: sup read/write, usr read
  - 3: sup and usr read/write
  - 4: sup and usr read
  - 5: sup write only
  - 6 and 7: no access
- R8: Code bit 3 grants execute. Outside module windows a fetch passes only when bit 3 is 1 and the same privilege level has read rights under R7.
- R9: acc_ok or acc_err, never both, is high in the same cycle as acc_valid. Both stay low while acc_valid is low.
- R10: After reset, module windows allow supervisor reads and writes and refuse user reads and writes.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_wr | input | 1 | Configuration write strobe |
| cfg_rd | input | 1 | Configuration read strobe |
| cfg_addr | input | 4 | Configuration byte offset |
| cfg_wdata | input | 8 | Configuration write data |
| cfg_rdata | output | 8 | Configuration read data, registered |
| acc_valid | input | 1 | Peripheral access present this cycle |
| acc_addr | input | 30 | Access offset within the peripheral window |
| acc_kind | input | 2 | 00 read, 01 write, 10/11 instruction fetch |
| acc_super | input | 1 | 1 for supervisor, 0 for user |
| acc_ok | output | 1 | Access allowed |
| acc_err | output | 1 | Access terminated with error |

## Verification
The bench aims at the priority seam between the two tiers. It closes region 0 while opening a module, and the other way round. A design that consulted the group register, or merged both codes, would then pass or refuse the wrong accesses. It sweeps all sixteen codes against both privilege levels and all three access kinds, so a swapped table row or an execute bit that skipped the read check shows up at once. It writes a cleared lock bit over a locked register to catch a lock that only guards the code bits. It also probes the first reserved region, the last one, and the offset just past the last module window, where an off-by-one decode would answer with the wrong register.

// File: rtl/periph_guard_pkg.sv
package periph_guard_pkg;

  typedef enum logic [1:0] {
    ACC_RD    = 2'b00,
    ACC_WR    = 2'b01,
    ACC_FETCH = 2'b10,
    ACC_FALT  = 2'b11
  } acc_kind_e;

  typedef struct packed {
    logic sup_rd;
    logic sup_wr;
    logic usr_rd;
    logic usr_wr;
    logic exec;
  } perm_t;

  function automatic perm_t code_to_perm(logic [3:0] code);
    perm_t p;
    p = '0;
    case (code[2:0])
      3'd0: begin p.sup_rd = 1'b1; p.sup_wr = 1'b1; end
      3'd1: begin p.sup_rd = 1'b1; end
      3'd2: begin p.sup_rd = 1'b1; p.sup_wr = 1'b1; p.usr_rd = 1'b1; end
      3'd3: begin p.sup_rd = 1'b1; p.sup_wr = 1'b1; p.usr_rd = 1'b1; p.usr_wr = 1'b1; end
      3'd4: begin p.sup_rd = 1'b1; p.usr_rd = 1'b1; end
      3'd5: begin p.sup_wr = 1'b1; end
      default: p = '0;
    endcase
    p.exec = code[3];
    return p;
  endfunction

endpackage

// File: rtl/pg_regfile.sv
module pg_regfile #(
  parameter int NUM_MODS = 8,
  parameter int NUM_GRP  = 2,
  parameter int CODE_W   = 4,
  parameter int CFG_AW   = 4
) (
  input  logic                              clk,
  input  logic                              rst,
  input  logic                              cfg_wr,
  input  logic                              cfg_rd,
  input  logic [CFG_AW-1:0]                 cfg_addr,
  input  logic [7:0]                        cfg_wdata,
  output logic [7:0]                        cfg_rdata,
  output logic [NUM_MODS-1:0][CODE_W-1:0]   mod_code_o,
  output logic [NUM_GRP-1:0][CODE_W-1:0]    grp_code_o
);

  localparam int GRP_BASE = NUM_MODS;
  localparam int GRP_END  = NUM_MODS + NUM_GRP;

  logic [CODE_W-1:0] mod_q [NUM_MODS];
  logic [CODE_W-1:0] grp_q [NUM_GRP];
  logic              grp_lock [NUM_GRP];
  logic              unused_wd;

  assign unused_wd = ^cfg_wdata[6:CODE_W];

  // module code storage: plain writes, no lock
  genvar m;
  generate
    for (m = 0; m < NUM_MODS; m++) begin : g_mod
      always_ff @(posedge clk) begin
        if (rst) begin
          mod_q[m] <= '0;
        end else if (cfg_wr && (int'(cfg_addr) == m)) begin
          mod_q[m] <= cfg_wdata[CODE_W-1:0];
        end
      end
      assign mod_code_o[m] = mod_q[m];
    end
  endgenerate

  // group registers with sticky lock
  genvar g;
  generate
    for (g = 0; g < NUM_GRP; g++) begin : g_grp
      always_ff @(posedge clk) begin
        if (rst) begin
          grp_q[g]    <= '0;
          grp_lock[g] <= 1'b0;
        end else if (cfg_wr && !grp_lock[g] && (int'(cfg_addr) == GRP_BASE + g)) begin
          grp_q[g]    <= cfg_wdata[CODE_W-1:0];
          grp_lock[g] <= cfg_wdata[7];
        end
      end
      assign grp_code_o[g] = grp_q[g];

      // R3
      lock_hold_chk: assert property (@(posedge clk) disable iff (rst)
        grp_lock[g] |=> ($stable(grp_lock[g]) && $stable(grp_q[g])));
    end
  endgenerate

  // registered readback
  always_ff @(posedge clk) begin
    if (rst) begin
      cfg_rdata <= '0;
    end else if (cfg_rd) begin
      cfg_rdata <= '0;
      if (int'(cfg_addr) < GRP_BASE) begin
        cfg_rdata[CODE_W-1:0] <= mod_q[cfg_addr[$clog2(NUM_MODS)-1:0]];
      end else if (int'(cfg_addr) < GRP_END) begin
        for (int i = 0; i < NUM_GRP; i++) begin
          if (int'(cfg_addr) == GRP_BASE + i) begin
            cfg_rdata[CODE_W-1:0] <= grp_q[i];
            cfg_rdata[7]          <= grp_lock[i];
          end
        end
      end
    end
  end

  // R2
  rsvd_zero_chk: assert property (@(posedge clk) disable iff (rst)
    cfg_rdata[6:4] == 3'b000);

endmodule

// File: rtl/pg_addr_dec.sv
module pg_addr_dec #(
  parameter int ADDR_W     = 30,
  parameter int REGION_LSB = 26,
  parameter int REGION_W   = 4,
  parameter int MOD_SHIFT  = 16,
  parameter int NUM_MODS   = 8,
  parameter int NUM_GRP    = 2,
  parameter int CODE_W     = 4
) (
  input  logic [ADDR_W-1:0]                 addr,
  input  logic [NUM_MODS-1:0][CODE_W-1:0]   mod_code,
  input  logic [NUM_GRP-1:0][CODE_W-1:0]    grp_code,
  output logic                              reserved,
  output logic                              mod_hit,
  output logic [CODE_W-1:0]                 sel_code
);

  localparam int MIDX_FULL_W = REGION_LSB - MOD_SHIFT;
  localparam int MOD_IDX_W   = (NUM_MODS > 1) ? $clog2(NUM_MODS) : 1;
  localparam int GRP_IDX_W   = (NUM_GRP > 1) ? $clog2(NUM_GRP) : 1;

  logic [REGION_W-1:0]    region;
  logic [MIDX_FULL_W-1:0] midx_full;
  logic [MOD_IDX_W-1:0]   midx;
  logic [GRP_IDX_W-1:0]   gidx;
  logic                   unused_low;

  assign unused_low = ^addr[MOD_SHIFT-1:0];
  assign region     = addr[REGION_LSB +: REGION_W];
  assign midx_full  = addr[MOD_SHIFT +: MIDX_FULL_W];
  assign midx       = midx_full[MOD_IDX_W-1:0];
  assign gidx       = region[GRP_IDX_W-1:0];

  assign reserved = (int'(region) >= NUM_GRP);
  assign mod_hit  = (region == '0) && (int'(midx_full) < NUM_MODS);

  // module field takes precedence over the enclosing group register
  always_comb begin
    if (mod_hit) sel_code = mod_code[midx];
    else         sel_code = grp_code[gidx];
  end

endmodule

// File: rtl/pg_perm_eval.sv
module pg_perm_eval
  import periph_guard_pkg::*;
#(
  parameter int CODE_W = 4
) (
  input  logic [CODE_W-1:0] code,
  input  logic              super_mode,
  input  logic [1:0]        kind,
  output logic              allow
);

  perm_t p;
  logic  rd_ok;

  assign p     = code_to_perm(code);
  assign rd_ok = super_mode ? p.sup_rd : p.usr_rd;

  always_comb begin
    case (acc_kind_e'(kind))
      ACC_RD:  allow = rd_ok;
      ACC_WR:  allow = super_mode ? p.sup_wr : p.usr_wr;
      default: allow = p.exec && rd_ok;
    endcase
  end

endmodule

// File: rtl/periph_guard.sv
module periph_guard
  import periph_guard_pkg::*;
#(
  parameter int ADDR_W     = 30,
  parameter int REGION_LSB = 26,
  parameter int REGION_W   = 4,
  parameter int MOD_SHIFT  = 16,
  parameter int NUM_MODS   = 8,
  parameter int NUM_GRP    = 2,
  parameter int CODE_W     = 4,
  parameter int CFG_AW     = $clog2(NUM_MODS + NUM_GRP)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cfg_wr,
  input  logic              cfg_rd,
  input  logic [CFG_AW-1:0] cfg_addr,
  input  logic [7:0]        cfg_wdata,
  output logic [7:0]        cfg_rdata,
  input  logic              acc_valid,
  input  logic [ADDR_W-1:0] acc_addr,
  input  logic [1:0]        acc_kind,
  input  logic              acc_super,
  output logic              acc_ok,
  output logic              acc_err
);

  logic [NUM_MODS-1:0][CODE_W-1:0] mod_code;
  logic [NUM_GRP-1:0][CODE_W-1:0]  grp_code;
  logic                            reserved;
  logic                            mod_hit;
  logic [CODE_W-1:0]               sel_code;
  logic                            code_allow;
  logic                            is_fetch;
  logic                            deny;

  pg_regfile #(
    .NUM_MODS (NUM_MODS),
    .NUM_GRP  (NUM_GRP),
    .CODE_W   (CODE_W),
    .CFG_AW   (CFG_AW)
  ) u_regs (
    .clk        (clk),
    .rst        (rst),
    .cfg_wr     (cfg_wr),
    .cfg_rd     (cfg_rd),
    .cfg_addr   (cfg_addr),
    .cfg_wdata  (cfg_wdata),
    .cfg_rdata  (cfg_rdata),
    .mod_code_o (mod_code),
    .grp_code_o (grp_code)
  );

  pg_addr_dec #(
    .ADDR_W     (ADDR_W),
    .REGION_LSB (REGION_LSB),
    .REGION_W   (REGION_W),
    .MOD_SHIFT  (MOD_SHIFT),
    .NUM_MODS   (NUM_MODS),
    .NUM_GRP    (NUM_GRP),
    .CODE_W     (CODE_W)
  ) u_dec (
    .addr     (acc_addr),
    .mod_code (mod_code),
    .grp_code (grp_code),
    .reserved (reserved),
    .mod_hit  (mod_hit),
    .sel_code (sel_code)
  );

  pg_perm_eval #(
    .CODE_W (CODE_W)
  ) u_perm (
    .code       (sel_code),
    .super_mode (acc_super),
    .kind       (acc_kind),
    .allow      (code_allow)
  );

  assign is_fetch = acc_kind[1];
  assign deny     = reserved || (mod_hit && is_fetch) || !code_allow;
  assign acc_ok   = acc_valid && !deny;
  assign acc_err  = acc_valid && deny;

  // R4
  reserved_err_chk: assert property (@(posedge clk) disable iff (rst)
    (acc_valid && (int'(acc_addr[REGION_LSB +: REGION_W]) >= NUM_GRP)) |-> acc_err);

  // R6
  mod_fetch_err_chk: assert property (@(posedge clk) disable iff (rst)
    (acc_valid && mod_hit && acc_kind[1]) |-> acc_err);

  // R9
  one_resp_chk: assert property (@(posedge clk) disable iff (rst)
    acc_valid |-> $onehot({acc_ok, acc_err}));

  // R9
  idle_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    !acc_valid |-> (!acc_ok && !acc_err));

endmodule

// File: tb/periph_guard_tb.sv
module periph_guard_tb;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        cfg_wr = 1'b0;
  logic        cfg_rd = 1'b0;
  logic [3:0]  cfg_addr = '0;
  logic [7:0]  cfg_wdata = '0;
  logic [7:0]  cfg_rdata;
  logic        acc_valid = 1'b0;
  logic [29:0] acc_addr = '0;
  logic [1:0]  acc_kind = '0;
  logic        acc_super = 1'b0;
  logic        acc_ok;
  logic        acc_err;

  int n_tests = 0;
  int n_fail  = 0;

  always #10 clk = ~clk;

  periph_guard u_dut (
    .clk       (clk),
    .rst       (rst),
    .cfg_wr    (cfg_wr),
    .cfg_rd    (cfg_rd),
    .cfg_addr  (cfg_addr),
    .cfg_wdata (cfg_wdata),
    .cfg_rdata (cfg_rdata),
    .acc_valid (acc_valid),
    .acc_addr  (acc_addr),
    .acc_kind  (acc_kind),
    .acc_super (acc_super),
    .acc_ok    (acc_ok),
    .acc_err   (acc_err)
  );

  function automatic logic [29:0] reg_addr(int r);
    return 30'(r) << 26;
  endfunction

  function automatic logic [29:0] mod_addr(int m);
    return 30'(m) << 16;
  endfunction

  // independent rights model: kind 0 read, 1 write, 2 fetch
  function automatic bit model_allow(int code, bit sup, int kind);
    bit sr, sw, ur, uw;
    {sr, sw, ur, uw} = 4'b0000;
    case (code % 8)
      0: {sr, sw, ur, uw} = 4'b1100;
      1: {sr, sw, ur, uw} = 4'b1000;
      2: {sr, sw, ur, uw} = 4'b1110;
      3: {sr, sw, ur, uw} = 4'b1111;
      4: {sr, sw, ur, uw} = 4'b1010;
      5: {sr, sw, ur, uw} = 4'b0100;
      default: {sr, sw, ur, uw} = 4'b0000;
    endcase
    if (kind == 0) return sup ? sr : ur;
    if (kind == 1) return sup ? sw : uw;
    return (code >= 8) && (sup ? sr : ur);
  endfunction

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic cfg_write(int a, logic [7:0] d);
    @(negedge clk);
    cfg_wr = 1'b1; cfg_addr = 4'(a); cfg_wdata = d;
    @(negedge clk);
    cfg_wr = 1'b0;
  endtask

  task automatic cfg_read(int a, output logic [7:0] d);
    @(negedge clk);
    cfg_rd = 1'b1; cfg_addr = 4'(a);
    @(negedge clk);
    cfg_rd = 1'b0;
    d = cfg_rdata;
  endtask

  task automatic access(string req, logic [29:0] a, int kind, bit sup, bit exp_ok);
    @(negedge clk);
    acc_valid = 1'b1; acc_addr = a; acc_kind = 2'(kind); acc_super = sup;
    #1;
    check(req, {30'd0, acc_ok, acc_err}, {30'd0, exp_ok, !exp_ok});
    @(negedge clk);
    acc_valid = 1'b0;
  endtask

  task automatic t_reset;
    logic [7:0] d;
    for (int a = 0; a < 10; a++) begin
      cfg_read(a, d);
      check("R1 reset readback", {24'd0, d}, 32'h0);
    end
    access("R10 sup read module", mod_addr(3), 0, 1'b1, 1'b1);
    access("R10 sup write module", mod_addr(3), 1, 1'b1, 1'b1);
    access("R10 usr read module", mod_addr(3), 0, 1'b0, 1'b0);
    access("R10 usr write module", mod_addr(7), 1, 1'b0, 1'b0);
  endtask

  task automatic t_regbus;
    logic [7:0] d;
    cfg_write(5, 8'hFA);
    cfg_read(5, d);
    check("R2 module byte upper zero", {24'd0, d}, 32'h0A);
    cfg_write(8, 8'h76);
    cfg_read(8, d);
    check("R2 group bits 6:4 zero", {24'd0, d}, 32'h06);
    cfg_write(12, 8'hFF);
    cfg_read(12, d);
    check("R2 unmapped offset reads zero", {24'd0, d}, 32'h0);
    cfg_write(5, 8'h00);
    cfg_write(8, 8'h00);
  endtask

  task automatic t_idle;
    @(negedge clk);
    acc_valid = 1'b0; acc_addr = reg_addr(5); acc_kind = 2'd0; acc_super = 1'b1;
    #1;
    check("R9 idle no response", {30'd0, acc_ok, acc_err}, 32'h0);
  endtask

  task automatic t_reserved;
    cfg_write(8, 8'h0B);
    cfg_write(9, 8'h0B);
    access("R4 region 2 error", reg_addr(2), 0, 1'b1, 1'b0);
    access("R4 region 15 error", reg_addr(15) | 30'h123, 1, 1'b1, 1'b0);
    access("R4 region 1 allowed", reg_addr(1), 0, 1'b0, 1'b1);
  endtask

  task automatic t_priority;
    cfg_write(8, 8'h07);
    cfg_write(2, 8'h03);
    access("R5 module open, region 0 closed", mod_addr(2), 1, 1'b0, 1'b1);
    access("R5 past last module uses region 0", mod_addr(8), 0, 1'b1, 1'b0);
    cfg_write(8, 8'h03);
    cfg_write(6, 8'h07);
    access("R5 module closed, region 0 open", mod_addr(6) | 30'h0044, 0, 1'b1, 1'b0);
    access("R5 region 0 outside modules open", mod_addr(9), 1, 1'b0, 1'b1);
  endtask

  task automatic t_fetch_module;
    cfg_write(4, 8'h0B);
    access("R6 fetch module exec code sup", mod_addr(4), 2, 1'b1, 1'b0);
    access("R6 fetch module alt kind usr", mod_addr(4), 3, 1'b0, 1'b0);
    cfg_write(8, 8'h0B);
    access("R8 fetch region 0 outside modules", mod_addr(8), 2, 1'b1, 1'b1);
  endtask

  task automatic t_codes;
    for (int code = 0; code < 16; code++) begin
      cfg_write(9, 8'(code));
      for (int sup = 0; sup < 2; sup++) begin
        for (int kind = 0; kind < 3; kind++) begin
          access(kind == 2 ? "R8 exec code sweep" : "R7 rights code sweep",
                 reg_addr(1) | 30'h1000, kind, sup[0],
                 model_allow(code, sup[0], kind));
        end
      end
    end
  endtask

  task automatic t_lock;
    logic [7:0] d;
    cfg_write(9, 8'h83);
    cfg_read(9, d);
    check("R3 lock readback", {24'd0, d}, 32'h83);
    cfg_write(9, 8'h00);
    cfg_read(9, d);
    check("R3 write ignored while locked", {24'd0, d}, 32'h83);
    access("R3 locked code still applies", reg_addr(1), 1, 1'b0, 1'b1);
    cfg_write(8, 8'h05);
    cfg_read(8, d);
    check("R3 other group unlocked", {24'd0, d}, 32'h05);
  endtask

  initial begin
    #(20 * 100000);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    t_reset();
    t_regbus();
    t_idle();
    t_reserved();
    t_priority();
    t_fetch_module();
    t_codes();
    t_lock();
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

endmodule